// File: doc/BRIEF.md
# Reset Release Phase Aligner

This block takes a raw, asynchronous, active-low processor reset and produces a re-timed copy. The copy goes low at once when the raw reset goes low. It goes high again only at a chosen point of a half-rate clock phase derived from the fast input clock. During reset, the processor latches a boot-width strap on the rising edge of its memory clock. That clock runs at exactly half the input clock rate. If a memory-clock rising edge falls inside the skew between the reset release and the strap settling, the wrong boot width is latched.

The block never uses the memory clock, because that clock is not guaranteed to run before the processor leaves reset. Only the input clock drives it. A free-running divide-by-two inside the block gives the memory-clock phase, and this phase is brought out as `mem_phase`.

A one-hot parameter selects one of two release styles:
- **Rising mode:** release on the input-clock rising edge at which the phase falls. The next phase rise is then a full input period away.
- **Falling mode:** release on the input-clock falling edge in the middle of the phase-high half. The skew then has half an input period to settle before the next input rising edge.

Top module: `reset_phase_aligner`

## Requirements
- R1: When `rst_raw_n` goes low, `rst_sync_n` goes low in the same time step without waiting for a clock edge, and stays low while `rst_raw_n` is low.
- R2: `rst_sync_n` rises only after `rst_raw_n` has been high for at least `SYNC_STAGES` input-clock rising edges (default 2).
- R3: With `RELEASE_MODE` = 2'b01 (rising mode), `rst_sync_n` rises exactly on an input-clock rising edge at which `mem_phase` goes from 1 to 0.
- R4: With `RELEASE_MODE` = 2'b10 (falling mode), `rst_sync_n` rises exactly on an input-clock falling edge while `mem_phase` is 1.
- R5: In either mode, the time from any rise of `rst_sync_n` to the nearest rising edge of `mem_phase` is at least half an input-clock period.
- R6: `rst_sync_n` is high no later than `SYNC_STAGES`+2 input-clock rising edges after the last rise of `rst_raw_n`.
- R7: `mem_phase` starts at 0 and toggles on every input-clock rising edge, whatever the state of reset.
- R8: A low pulse on `rst_raw_n` while a release is pending restarts the wait. The R2 and R6 bounds then count from the last rise of `rst_raw_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock, twice the memory-clock rate |
| rst_raw_n | input | 1 | Raw asynchronous active-low reset |
| rst_sync_n | output | 1 | Phase-aligned active-low reset; asserts at once, releases on the aligned edge |
| mem_phase | output | 1 | Input clock divided by two, tracking the memory-clock phase |

## Verification
The hard case is a raw release that lands at an arbitrary point in the four-input-edge cycle of phase and synchronizer. Only those landings show whether the aligner waits an extra input cycle for the right phase instead of releasing at the first synchronized edge.

The bench raises the raw reset at table-driven and random sub-cycle offsets after a varying number of idle cycles. For each release it measures the absolute time against a phase model the bench keeps itself. It also drops the reset briefly during a pending release, to check that the wait restarts.

// File: rtl/rpa_pkg.sv
`timescale 1ns/1ps
package rpa_pkg;
  // One-hot release-mode encodings
  localparam logic [1:0] REL_ON_RISE = 2'b01;
  localparam logic [1:0] REL_ON_FALL = 2'b10;

  function automatic bit mode_is_rise(input logic [1:0] mode);
    return mode == REL_ON_RISE;
  endfunction

  function automatic bit mode_is_legal(input logic [1:0] mode);
    return (mode == REL_ON_RISE) || (mode == REL_ON_FALL);
  endfunction

  // Release is allowed while the synchronized reset is high and the divided
  // phase is high:
  //  - rising mode samples this before the edge that drops the phase
  //  - falling mode samples it mid-way through the high half
  function automatic logic release_window(input logic phase_q, input logic synced);
    return synced & phase_q;
  endfunction
endpackage

// File: rtl/rpa_phase_divider.sv
`timescale 1ns/1ps
module rpa_phase_divider (
  input  logic clk_in,
  output logic phase_q
);
  // Free running: the memory-clock phase exists independently of reset.
  logic div_q = 1'b0;

  always_ff @(posedge clk_in) begin
    div_q <= ~div_q;
  end

  assign phase_q = div_q;
endmodule

// File: rtl/rpa_reset_sync.sv
`timescale 1ns/1ps
module rpa_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_in,
  input  logic rst_raw_n,
  output logic synced
);
  // STAGES must be at least 2.
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk_in or negedge rst_raw_n) begin
    if (!rst_raw_n) chain <= '0;
    else            chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign synced = chain[STAGES-1];
endmodule

// File: rtl/rpa_release_stage.sv
`timescale 1ns/1ps
module rpa_release_stage #(
  parameter logic [1:0] RELEASE_MODE = rpa_pkg::REL_ON_RISE
) (
  input  logic clk_in,
  input  logic rst_raw_n,
  input  logic release_en,
  output logic release_q
);
  localparam bit IS_RISE = rpa_pkg::mode_is_rise(RELEASE_MODE);

  logic rel_q;

  generate
    if (IS_RISE) begin : g_rise
      always_ff @(posedge clk_in or negedge rst_raw_n) begin
        if (!rst_raw_n)      rel_q <= 1'b0;
        else if (release_en) rel_q <= 1'b1;
      end
    end else begin : g_fall
      always_ff @(negedge clk_in or negedge rst_raw_n) begin
        if (!rst_raw_n)      rel_q <= 1'b0;
        else if (release_en) rel_q <= 1'b1;
      end
    end
  endgenerate

  assign release_q = rel_q;
endmodule

// File: rtl/reset_phase_aligner.sv
`timescale 1ns/1ps
module reset_phase_aligner #(
  parameter logic [1:0] RELEASE_MODE = rpa_pkg::REL_ON_RISE,
  parameter int         SYNC_STAGES  = 2
) (
  input  logic clk_in,
  input  logic rst_raw_n,
  output logic rst_sync_n,
  output logic mem_phase
);
  localparam bit MODE_OK = rpa_pkg::mode_is_legal(RELEASE_MODE);

  // Named internal events, visible to the bound checker
  logic phase_q;
  logic sync_ok;
  logic release_en;
  logic release_q;

  rpa_phase_divider u_div (
    .clk_in  (clk_in),
    .phase_q (phase_q)
  );

  rpa_reset_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_in    (clk_in),
    .rst_raw_n (rst_raw_n),
    .synced    (sync_ok)
  );

  assign release_en = MODE_OK && rpa_pkg::release_window(phase_q, sync_ok);

  rpa_release_stage #(.RELEASE_MODE(RELEASE_MODE)) u_rel (
    .clk_in     (clk_in),
    .rst_raw_n  (rst_raw_n),
    .release_en (release_en),
    .release_q  (release_q)
  );

  assign rst_sync_n = release_q;
  assign mem_phase  = phase_q;
endmodule

// File: rtl/rpa_checker.sv
`timescale 1ns/1ps
module rpa_checker #(
  parameter logic [1:0] RELEASE_MODE = rpa_pkg::REL_ON_RISE
) (
  input logic clk_in,
  input logic rst_raw_n,
  input logic rst_sync_n,
  input logic mem_phase,
  input logic sync_ok
);
  localparam bit IS_RISE = rpa_pkg::mode_is_rise(RELEASE_MODE);

  // R1
  hold_low_chk: assert property (@(posedge clk_in)
    !rst_raw_n |-> !rst_sync_n);

  // R2
  release_gated_chk: assert property (@(posedge clk_in) disable iff (!rst_raw_n)
    rst_sync_n |-> sync_ok);

  // R6
  release_deadline_chk: assert property (@(posedge clk_in) disable iff (!rst_raw_n)
    (sync_ok && $past(sync_ok) && $past(sync_ok, 2)) |-> rst_sync_n);

  // R7
  phase_toggle_chk: assert property (@(posedge clk_in) disable iff (!rst_raw_n)
    mem_phase != $past(mem_phase));

  generate
    if (IS_RISE) begin : g_rise_chk
      // R3
      rise_phase_chk: assert property (@(posedge clk_in) disable iff (!rst_raw_n)
        $rose(rst_sync_n) |-> (!mem_phase && $past(mem_phase)));
    end else begin : g_fall_chk
      // R4
      fall_phase_chk: assert property (@(posedge clk_in) disable iff (!rst_raw_n)
        $rose(rst_sync_n) |-> mem_phase);
    end
  endgenerate
endmodule

bind reset_phase_aligner rpa_checker #(.RELEASE_MODE(RELEASE_MODE)) u_chk (
  .clk_in     (clk_in),
  .rst_raw_n  (rst_raw_n),
  .rst_sync_n (rst_sync_n),
  .mem_phase  (mem_phase),
  .sync_ok    (sync_ok)
);

// File: tb/reset_phase_aligner_tb_top.sv
`timescale 1ns/1ps
module reset_phase_aligner_tb_top;
  localparam int  SYNC   = 2;
  localparam real TCLK   = 5.0;   // 200 MHz input clock
  localparam real FIRST  = 2.5;   // first rising edge of clk
  localparam real TOL    = 0.01;
  // {idle cycles before release, offset after a falling edge in 0.1 ns}
  localparam int NVEC = 8;
  localparam int VEC [NVEC][2] = '{
    '{1, 3}, '{2, 11}, '{1, 20}, '{3, 24},
    '{2, 26}, '{1, 37}, '{4, 44}, '{2, 49}
  };

  logic clk = 1'b0;
  logic raw_n = 1'b1;
  logic rsr_n, rsf_n, ph_r, ph_f;
  logic mclk = 1'b0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;
  real  rel_r = -1.0;
  real  rel_f = -1.0;

  always #2.5 clk = ~clk;
  always @(posedge clk) mclk <= ~mclk;   // bench model of the memory clock

  always @(posedge rsr_n) rel_r = $realtime;
  always @(posedge rsf_n) rel_f = $realtime;

  reset_phase_aligner #(.RELEASE_MODE(2'b01), .SYNC_STAGES(SYNC)) dut_i (
    .clk_in(clk), .rst_raw_n(raw_n), .rst_sync_n(rsr_n), .mem_phase(ph_r));
  reset_phase_aligner #(.RELEASE_MODE(2'b10), .SYNC_STAGES(SYNC)) dut_f (
    .clk_in(clk), .rst_raw_n(raw_n), .rst_sync_n(rsf_n), .mem_phase(ph_f));

  task automatic chk(input bit ok, input string req, input real act, input real exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", req, act, exp);
    end
  endtask

  // Distance from t to the last model memory-clock rise (rises at 2.5 + 10k ns)
  function automatic real since_rise(input real t);
    real x = (t - FIRST) / (2.0 * TCLK);
    return (x - $floor(x)) * 2.0 * TCLK;
  endfunction

  function automatic int edges_between(input real tr, input real tl);
    return int'($floor((tl - FIRST) / TCLK) - $floor((tr - FIRST) / TCLK));
  endfunction

  task automatic check_release(input real tl, input real tr, input bit rise);
    int  n;
    real d, near;
    n = (tl < 0.0) ? 99 : edges_between(tr, tl);
    // R2: not before SYNC rising edges after the raw rise
    chk(n >= SYNC, rise ? "R2 rise-mode edge count" : "R2 fall-mode edge count", n, SYNC);
    // R6: no later than SYNC+2 rising edges
    chk(n <= SYNC + 2, rise ? "R6 rise-mode edge count" : "R6 fall-mode edge count", n, SYNC + 2);
    d = since_rise(tl);
    near = (d < 2.0 * TCLK - d) ? d : 2.0 * TCLK - d;
    if (rise) begin
      // R3: on the rising edge where the phase falls (5 ns after a phase rise)
      chk((d > 5.0 - TOL) && (d < 5.0 + TOL), "R3 release offset from phase rise", d, 5.0);
    end else begin
      // R4: on the falling edge in the phase-high half (2.5 ns after a phase rise)
      chk((d > 2.5 - TOL) && (d < 2.5 + TOL), "R4 release offset from phase rise", d, 2.5);
    end
    // R5: nearest phase rise at least half an input period away
    chk(near > TCLK / 2.0 - TOL, "R5 distance to nearest phase rise", near, TCLK / 2.0);
  endtask

  task automatic check_phase();
    @(negedge clk);
    // R7: mem_phase tracks the input clock divided by two
    chk(ph_r == mclk, "R7 mem_phase rise-mode dut", ph_r, mclk);
    chk(ph_f == mclk, "R7 mem_phase fall-mode dut", ph_f, mclk);
  endtask

  task automatic assert_now();
    raw_n = 1'b0;
    #0.2;
    // R1: immediate assertion without a clock edge
    chk(rsr_n == 1'b0, "R1 rise-mode async assert", rsr_n, 0);
    chk(rsf_n == 1'b0, "R1 fall-mode async assert", rsf_n, 0);
  endtask

  task automatic run_release(input int idle, input int off_t);
    real tr;
    repeat (idle) @(negedge clk);
    @(negedge clk);
    #(off_t * 0.1);
    raw_n = 1'b1;
    tr = $realtime;
    rel_r = -1.0;
    rel_f = -1.0;
    repeat (SYNC + 4) @(negedge clk);
    #1;
    check_release(rel_r, tr, 1'b1);
    check_release(rel_f, tr, 1'b0);
    assert_now();
  endtask

  initial begin
    #1 assert_now();                 // reset state at start
    repeat (3) check_phase();
    for (int i = 0; i < NVEC; i++) begin
      run_release(VEC[i][0], VEC[i][1]);
      check_phase();
    end
    for (int i = 0; i < 10; i++) begin
      int off = $urandom_range(1, 48);
      if (off == 25) off = 26;
      run_release($urandom_range(0, 3), off);
    end
    // R8: a short low pulse during a pending release restarts the wait
    begin
      real tr;
      @(negedge clk);
      #0.4 raw_n = 1'b1;
      @(negedge clk);
      #0.3 raw_n = 1'b0;
      #0.6 raw_n = 1'b1;
      tr = $realtime;
      rel_r = -1.0;
      rel_f = -1.0;
      repeat (SYNC + 4) @(negedge clk);
      #1;
      check_release(rel_r, tr, 1'b1);   // R8 bounds from the last rise
      check_release(rel_f, tr, 1'b0);   // R8 bounds from the last rise
      assert_now();
    end
    // R1: glitch after release still asserts at once
    run_release(1, 15);
    check_phase();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule